// File: doc/BRIEF.md
# Iterative 64-Point FFT/IFFT Engine

This block computes a 64-point complex discrete Fourier transform, or its inverse, on frames that arrive as a stream of one sample per clock. A frame opens with a sample flagged as start-of-frame. Each sample is written to a working store at the bit-reversed copy of its index. Once the 64th sample is in, a sequencer walks one pipelined radix-2 decimation-in-time butterfly across six stages of 32 butterflies each. Every butterfly writes its two results back over its two operands.

After the last stage the 64 results leave in natural index order, one per clock, with their own valid and start-of-frame flags. A mode bit, captured with the start-of-frame sample, selects the inverse transform. For the inverse the block reuses the forward datapath: it exchanges real and imaginary parts on the way in and on the way out, and scales the result by 1/64.

While a frame is being computed or drained, `ready` is low and input samples are dropped. Upstream logic waits for `ready` before it opens the next frame.

Top module: `fft64_iter`

## Requirements
- R1: A synchronous active-high `rst` puts the block into the idle load state on the next edge: `ready` = 1, `out_valid` = 0, `out_sop` = 0. A frame that was loading or computing is abandoned and produces no output.
- R2: While `ready` = 1, a sample with `in_valid` = 1 and `in_sop` = 1 opens a frame as index 0. Each later sample with `in_valid` = 1 takes the next index, up to 63. Sample n is stored at the 6-bit bit-reversed location of n. Computation starts after index 63.
- R3: Each butterfly computes P = xq·W with four 16×16 signed products, each sum or difference kept wide. It forms xp·2^13 ± P and keeps bits [28:13] of each sum as the new 16-bit two's-complement value, dropping 13 fraction bits with truncation toward minus infinity.
- R4: Stages run s = 0..5. Butterfly k (0..31) has group g = k >> s and member j = k mod 2^s. The upper location is g·2^(s+1) + j, the lower is the upper plus 2^s, and the twiddle index is r = j·2^(5−s). The twiddle W^r has real part floor(8192·cos(2πr/64)) and imaginary part floor(−8192·sin(2πr/64)).
- R5: A stage starts reading only after every write of the previous stage has landed.
- R6: The mode `inv` is sampled only with the `in_sop` sample; its level on other samples has no effect. With mode 1, the real and imaginary parts of every input are exchanged at load. Each output is the exchanged pair, each part arithmetic-shifted right by 6. With mode 0, no exchange or shift is applied.
- R7: Results leave as 64 consecutive `out_valid` cycles, in natural order 0..63. `out_sop` is high only with result 0.
- R8: `ready` is low from the cycle after the 64th sample is taken until the cycle that presents result 63, when it is high again. Samples offered while `ready` = 0 are ignored and do not disturb the frame in progress.
- R9: While idle with no frame open, samples with `in_valid` = 1 and `in_sop` = 0 are ignored: `ready` stays high and no output appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inv | input | 1 | Mode, sampled with start of frame: 0 forward, 1 inverse |
| in_valid | input | 1 | Input sample present |
| in_sop | input | 1 | Input sample is index 0 of a frame |
| in_re | input | 16 | Input real part, two's complement |
| in_im | input | 16 | Input imaginary part, two's complement |
| ready | output | 1 | High while a new frame may be loaded |
| out_valid | output | 1 | Output result present |
| out_sop | output | 1 | Output result is index 0 |
| out_re | output | 16 | Result real part, two's complement |
| out_im | output | 16 | Result imaginary part, two's complement |

## Verification
The assertions rely on a few assumptions about the block's inputs:
- reset is held across at least one edge before traffic starts;
- no reset arrives in the middle of an output burst, since the burst-length property would read a cut-off burst as a fault;
- samples never need to be accepted while the engine is busy; the engine drops them anyway.

The stimulus meets these assumptions:
- It asserts reset only while idle or computing.
- It opens frames only after `ready` is seen high.
- It drives junk samples and stray start flags only while `ready` is low, or with `in_sop` low while idle, to show they are ignored.

Input magnitudes are kept to about ±300 so the six stages of growth stay inside 16 bits, although the reference model wraps in the same way as the datapath.

// File: rtl/fft_pkg.sv
package fft_pkg;

    localparam int LOGN  = 6;
    localparam int NPTS  = 1 << LOGN;
    localparam int HALF  = NPTS / 2;
    localparam int QTR   = HALF / 2;
    localparam int DW    = 16;
    localparam int FRAC  = 13;
    localparam int ACC_W = 2 * DW + 2;
    localparam int PAD   = ACC_W - DW - FRAC;
    localparam int STG_W = $clog2(LOGN);

    typedef logic [LOGN-1:0]  addr_t;
    typedef logic [LOGN-2:0]  tw_t;
    typedef logic [STG_W-1:0] stage_t;

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } cplx_t;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_EMIT  = 2'd3
    } phase_e;

    function automatic addr_t bit_rev(input addr_t a);
        addr_t r;
        for (int b = 0; b < LOGN; b++) r[b] = a[LOGN-1-b];
        return r;
    endfunction

    function automatic cplx_t swap_parts(input cplx_t c);
        cplx_t s;
        s.re = c.im;
        s.im = c.re;
        return s;
    endfunction

    // floor(8192 * cos(2*pi*k/64)) for the first quarter turn
    function automatic int quarter_cos(input int k);
        case (k)
            0:  return 8192;
            1:  return 8152;
            2:  return 8034;
            3:  return 7839;
            4:  return 7568;
            5:  return 7224;
            6:  return 6811;
            7:  return 6332;
            8:  return 5792;
            9:  return 5196;
            10: return 4551;
            11: return 3861;
            12: return 3134;
            13: return 2378;
            14: return 1598;
            15: return 802;
            default: return 0;
        endcase
    endfunction

    // Floor-quantised twiddle built from the quarter table by symmetry:
    // inexact values flip sign through floor(-v) = -floor(v) - 1.
    function automatic cplx_t twiddle(input tw_t idx);
        int r, k, vr, vi;
        cplx_t w;
        r = int'(idx);
        if (r <= QTR) vr = quarter_cos(r);
        else          vr = -quarter_cos(HALF - r) - 1;
        k = (r <= QTR) ? r : HALF - r;
        if (k == 0)        vi = 0;
        else if (k == QTR) vi = -quarter_cos(0);
        else               vi = -quarter_cos(QTR - k) - 1;
        w.re = DW'(vr);
        w.im = DW'(vi);
        return w;
    endfunction

endpackage

// File: rtl/fft_wmem.sv
module fft_wmem
    import fft_pkg::*;
(
    input  logic  clk,
    input  logic  we_a,
    input  addr_t wa_a,
    input  cplx_t wd_a,
    input  logic  we_b,
    input  addr_t wa_b,
    input  cplx_t wd_b,
    input  addr_t ra_p,
    input  addr_t ra_q,
    input  addr_t ra_o,
    output cplx_t rd_p,
    output cplx_t rd_q,
    output cplx_t rd_o
);

    cplx_t store [NPTS];

    always_ff @(posedge clk) begin
        if (we_a) store[wa_a] <= wd_a;
        if (we_b) store[wa_b] <= wd_b;
    end

    assign rd_p = store[ra_p];
    assign rd_q = store[ra_q];
    assign rd_o = store[ra_o];

endmodule

// File: rtl/fft_bfly.sv
module fft_bfly
    import fft_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_vld,
    input  addr_t in_pa,
    input  addr_t in_qa,
    input  cplx_t xp,
    input  cplx_t xq,
    input  cplx_t w,
    output logic  out_vld,
    output addr_t out_pa,
    output addr_t out_qa,
    output cplx_t yp,
    output cplx_t yq,
    output logic  busy
);

    logic v1, v2, v3;
    addr_t pa1, qa1, pa2, qa2, pa3, qa3;
    logic signed [2*DW-1:0]  m_rr, m_ii, m_ri, m_ir;
    logic signed [ACC_W-1:0] xa_re1, xa_im1, xa_re2, xa_im2, pr2, pi2;
    logic signed [ACC_W-1:0] sp_re, sp_im, sq_re, sq_im;
    cplx_t yp3, yq3;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
            v3 <= 1'b0;
        end else begin
            v1 <= in_vld;
            v2 <= v1;
            v3 <= v2;
        end
    end

    // step 1: partial products and aligned upper operand
    always_ff @(posedge clk) begin
        m_rr   <= (2*DW)'($signed(xq.re)) * (2*DW)'($signed(w.re));
        m_ii   <= (2*DW)'($signed(xq.im)) * (2*DW)'($signed(w.im));
        m_ri   <= (2*DW)'($signed(xq.re)) * (2*DW)'($signed(w.im));
        m_ir   <= (2*DW)'($signed(xq.im)) * (2*DW)'($signed(w.re));
        xa_re1 <= {{PAD{xp.re[DW-1]}}, xp.re, {FRAC{1'b0}}};
        xa_im1 <= {{PAD{xp.im[DW-1]}}, xp.im, {FRAC{1'b0}}};
        pa1    <= in_pa;
        qa1    <= in_qa;
    end

    // step 2: complex product
    always_ff @(posedge clk) begin
        pr2    <= ACC_W'(m_rr) - ACC_W'(m_ii);
        pi2    <= ACC_W'(m_ri) + ACC_W'(m_ir);
        xa_re2 <= xa_re1;
        xa_im2 <= xa_im1;
        pa2    <= pa1;
        qa2    <= qa1;
    end

    always_comb begin
        sp_re = xa_re2 + pr2;
        sp_im = xa_im2 + pi2;
        sq_re = xa_re2 - pr2;
        sq_im = xa_im2 - pi2;
    end

    // step 3: add/subtract and drop the fraction bits
    always_ff @(posedge clk) begin
        yp3.re <= sp_re[FRAC+DW-1:FRAC];
        yp3.im <= sp_im[FRAC+DW-1:FRAC];
        yq3.re <= sq_re[FRAC+DW-1:FRAC];
        yq3.im <= sq_im[FRAC+DW-1:FRAC];
        pa3    <= pa2;
        qa3    <= qa2;
    end

    assign out_vld = v3;
    assign out_pa  = pa3;
    assign out_qa  = qa3;
    assign yp      = yp3;
    assign yq      = yq3;
    assign busy    = v1 | v2 | v3;

    // R5
    bfly_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |-> ##3 out_vld);

endmodule

// File: rtl/fft_seq.sv
module fft_seq
    import fft_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_vld,
    input  logic  in_sop,
    input  logic  in_inv,
    input  logic  bf_busy,
    output logic  ready,
    output logic  ld_we,
    output logic  ld_inv,
    output addr_t ld_addr,
    output logic  iss_vld,
    output addr_t iss_pa,
    output addr_t iss_qa,
    output tw_t   iss_tw,
    output logic  emit_vld,
    output logic  emit_first,
    output addr_t emit_addr,
    output logic  inv_q
);

    phase_e phase;
    addr_t  cnt;
    stage_t stage;
    addr_t  idx;

    assign ready      = (phase == ST_LOAD);
    assign idx        = in_sop ? '0 : cnt;
    assign ld_we      = ready && in_vld && (in_sop || cnt != '0);
    assign ld_addr    = bit_rev(idx);
    assign ld_inv     = in_sop ? in_inv : inv_q;
    assign iss_vld    = (phase == ST_RUN);
    assign emit_vld   = (phase == ST_EMIT);
    assign emit_first = emit_vld && (cnt == '0);
    assign emit_addr  = cnt;

    // stage / group / member address arithmetic
    always_comb begin
        int s_i, k_i, grp, mbr, pa_i;
        s_i    = int'(stage);
        k_i    = int'(cnt[LOGN-2:0]);
        grp    = k_i >> s_i;
        mbr    = k_i & ((1 << s_i) - 1);
        pa_i   = (grp << (s_i + 1)) | mbr;
        iss_pa = addr_t'(pa_i);
        iss_qa = addr_t'(pa_i + (1 << s_i));
        iss_tw = tw_t'(mbr << (LOGN - 1 - s_i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= ST_LOAD;
            cnt   <= '0;
            stage <= '0;
            inv_q <= 1'b0;
        end else begin
            unique case (phase)
                ST_LOAD: if (ld_we) begin
                    if (in_sop) inv_q <= in_inv;
                    if (idx == addr_t'(NPTS - 1)) begin
                        phase <= ST_RUN;
                        cnt   <= '0;
                        stage <= '0;
                    end else begin
                        cnt <= idx + 1'b1;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt[LOGN-2:0] == tw_t'(HALF - 1)) begin
                        phase <= ST_DRAIN;
                        cnt   <= '0;
                    end
                end
                ST_DRAIN: if (!bf_busy) begin
                    cnt <= '0;
                    if (stage == stage_t'(LOGN - 1)) begin
                        phase <= ST_EMIT;
                    end else begin
                        stage <= stage + 1'b1;
                        phase <= ST_RUN;
                    end
                end
                ST_EMIT: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == addr_t'(NPTS - 1)) phase <= ST_LOAD;
                end
                default: phase <= ST_LOAD;
            endcase
        end
    end

    // R5
    stage_start_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_vld && cnt[LOGN-2:0] == '0) |-> !bf_busy);

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |=> $stable(inv_q));

endmodule

// File: rtl/fft64_iter.sv
module fft64_iter
    import fft_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 inv,
    input  logic                 in_valid,
    input  logic                 in_sop,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 ready,
    output logic                 out_valid,
    output logic                 out_sop,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im
);

    logic  ld_we, ld_inv, iss_vld, emit_vld, emit_first, inv_q;
    logic  bf_we, bf_busy;
    addr_t ld_addr, iss_pa, iss_qa, emit_addr, bf_pa, bf_qa;
    tw_t   iss_tw;
    cplx_t din, ld_data, rd_p, rd_q, rd_o, w, yp, yq;
    logic  [LOGN:0] vrun;

    assign din.re  = in_re;
    assign din.im  = in_im;
    assign ld_data = ld_inv ? swap_parts(din) : din;
    assign w       = twiddle(iss_tw);

    fft_seq i_seq (
        .clk        (clk),
        .rst        (rst),
        .in_vld     (in_valid),
        .in_sop     (in_sop),
        .in_inv     (inv),
        .bf_busy    (bf_busy),
        .ready      (ready),
        .ld_we      (ld_we),
        .ld_inv     (ld_inv),
        .ld_addr    (ld_addr),
        .iss_vld    (iss_vld),
        .iss_pa     (iss_pa),
        .iss_qa     (iss_qa),
        .iss_tw     (iss_tw),
        .emit_vld   (emit_vld),
        .emit_first (emit_first),
        .emit_addr  (emit_addr),
        .inv_q      (inv_q)
    );

    fft_wmem i_wmem (
        .clk  (clk),
        .we_a (ld_we | bf_we),
        .wa_a (ld_we ? ld_addr : bf_pa),
        .wd_a (ld_we ? ld_data : yp),
        .we_b (bf_we),
        .wa_b (bf_qa),
        .wd_b (yq),
        .ra_p (iss_pa),
        .ra_q (iss_qa),
        .ra_o (emit_addr),
        .rd_p (rd_p),
        .rd_q (rd_q),
        .rd_o (rd_o)
    );

    fft_bfly i_bfly (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (iss_vld),
        .in_pa   (iss_pa),
        .in_qa   (iss_qa),
        .xp      (rd_p),
        .xq      (rd_q),
        .w       (w),
        .out_vld (bf_we),
        .out_pa  (bf_pa),
        .out_qa  (bf_qa),
        .yp      (yp),
        .yq      (yq),
        .busy    (bf_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= emit_vld;
            out_sop   <= emit_first;
            if (emit_vld) begin
                if (inv_q) begin
                    out_re <= $signed(rd_o.im) >>> LOGN;
                    out_im <= $signed(rd_o.re) >>> LOGN;
                end else begin
                    out_re <= rd_o.re;
                    out_im <= rd_o.im;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) vrun <= '0;
        else     vrun <= out_valid ? vrun + 1'b1 : '0;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (ready && !out_valid && !out_sop));

    // R7
    sop_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> out_valid);

    // R7
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(out_valid) && !$past(rst)) |-> (vrun == (LOGN+1)'(NPTS)));

    // R8
    load_bfly_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ld_we && bf_we));

endmodule

// File: tb/test_fft64_iter.sv
module test_fft64_iter;

    localparam int CLK_PERIOD = 10;
    localparam real PI = 3.14159265358979323846;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inv = 1'b0;
    logic in_valid = 1'b0;
    logic in_sop = 1'b0;
    logic signed [15:0] in_re = '0;
    logic signed [15:0] in_im = '0;
    logic ready, out_valid, out_sop;
    logic signed [15:0] out_re, out_im;

    int n_checks = 0;
    int n_fail = 0;
    int seed = 7;
    int in_r [64];
    int in_i [64];
    int exp_r [64];
    int exp_i [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    fft64_iter i_fft64_iter (
        .clk       (clk),
        .rst       (rst),
        .inv       (inv),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_re     (in_re),
        .in_im     (in_im),
        .ready     (ready),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    task automatic chk(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int rnd(input int span);
        seed = seed * 1103515245 + 12345;
        return ((seed >> 16) & 32767) % (2 * span + 1) - span;
    endfunction

    function automatic int rev6(input int n);
        int r = 0;
        for (int b = 0; b < 6; b++) if ((n >> b) & 1) r |= 1 << (5 - b);
        return r;
    endfunction

    function automatic int wrap16(input longint v);
        return int'(shortint'(v));
    endfunction

    // Reference from the requirements: R2 load order, R3 arithmetic,
    // R4 addressing and twiddles, R6 inverse handling.
    task automatic compute_ref(input bit imode);
        int ar [64];
        int ai [64];
        for (int n = 0; n < 64; n++) begin
            ar[rev6(n)] = imode ? in_i[n] : in_r[n];
            ai[rev6(n)] = imode ? in_r[n] : in_i[n];
        end
        for (int s = 0; s < 6; s++) begin
            for (int k = 0; k < 32; k++) begin
                int g, j, p, q, t, wr, wi;
                longint pr, pim, xr, xi;
                g  = k >> s;
                j  = k & ((1 << s) - 1);
                p  = (g << (s + 1)) + j;
                q  = p + (1 << s);
                t  = j << (5 - s);
                wr = $rtoi($floor($cos(2.0 * PI * t / 64.0) * 8192.0));
                wi = $rtoi($floor(-$sin(2.0 * PI * t / 64.0) * 8192.0));
                pr  = longint'(ar[q]) * wr - longint'(ai[q]) * wi;
                pim = longint'(ar[q]) * wi + longint'(ai[q]) * wr;
                xr  = longint'(ar[p]) * 8192;
                xi  = longint'(ai[p]) * 8192;
                ar[p] = wrap16((xr + pr) >>> 13);
                ai[p] = wrap16((xi + pim) >>> 13);
                ar[q] = wrap16((xr - pr) >>> 13);
                ai[q] = wrap16((xi - pim) >>> 13);
            end
        end
        for (int k = 0; k < 64; k++) begin
            exp_r[k] = imode ? (ai[k] >>> 6) : ar[k];
            exp_i[k] = imode ? (ar[k] >>> 6) : ai[k];
        end
    endtask

    task automatic send_frame(input bit imode);
        int guard = 0;
        while (!ready && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        for (int n = 0; n < 64; n++) begin
            in_valid = 1'b1;
            in_sop   = (n == 0);
            inv      = (n == 0) ? imode : !imode;   // R6: only the sop level counts
            in_re    = 16'(in_r[n]);
            in_im    = 16'(in_i[n]);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_sop   = 1'b0;
        inv      = 1'b0;
    endtask

    task automatic collect(input string req);
        int guard = 0;
        while (!out_valid && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk("R7 burst start", out_valid, 1);
        for (int k = 0; k < 64; k++) begin
            if (k > 0) @(negedge clk);
            chk($sformatf("R7 valid[%0d]", k), out_valid, 1);
            chk($sformatf("R7 sop[%0d]", k), out_sop, (k == 0) ? 1 : 0);
            chk($sformatf("%s re[%0d]", req, k), int'(out_re), exp_r[k]);
            chk($sformatf("%s im[%0d]", req, k), int'(out_im), exp_i[k]);
            if (k == 0)  chk("R8 ready low at first result", ready, 0);
            if (k == 63) chk("R8 ready high at last result", ready, 1);
        end
        @(negedge clk);
        chk("R7 burst end", out_valid, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_reset_state();
        do_reset();
        chk("R1 ready after reset", ready, 1);
        chk("R1 out_valid after reset", out_valid, 0);
        chk("R1 out_sop after reset", out_sop, 0);
    endtask

    task automatic test_impulse();
        for (int n = 0; n < 64; n++) begin
            in_r[n] = (n == 0) ? 1000 : 0;
            in_i[n] = (n == 0) ? -500 : 0;
        end
        compute_ref(1'b0);
        chk("R3 impulse reference flat", exp_r[37], 1000);
        send_frame(1'b0);
        collect("R2 impulse");
    endtask

    task automatic test_ramp();
        for (int n = 0; n < 64; n++) begin
            in_r[n] = 3 * n - 90;
            in_i[n] = 50 - 2 * n;
        end
        compute_ref(1'b0);
        send_frame(1'b0);
        collect("R4 ramp");
    endtask

    task automatic test_busy_junk();
        for (int n = 0; n < 64; n++) begin
            in_r[n] = rnd(250);
            in_i[n] = rnd(250);
        end
        compute_ref(1'b0);
        send_frame(1'b0);
        chk("R8 ready low after last sample", ready, 0);
        for (int c = 0; c < 60; c++) begin
            in_valid = 1'b1;
            in_sop   = (c % 7 == 0);
            inv      = 1'b1;
            in_re    = 16'sd12345;
            in_im    = -16'sd9876;
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_sop   = 1'b0;
        inv      = 1'b0;
        collect("R8 junk while busy");
    endtask

    task automatic test_inverse();
        for (int n = 0; n < 64; n++) begin
            in_r[n] = rnd(300);
            in_i[n] = rnd(300);
        end
        compute_ref(1'b1);
        send_frame(1'b1);
        collect("R6 inverse");
        for (int n = 0; n < 64; n++) begin
            in_r[n] = (n % 2 == 0) ? 200 : -200;
            in_i[n] = 0;
        end
        compute_ref(1'b1);
        send_frame(1'b1);
        collect("R6 inverse alternating");
    endtask

    task automatic test_no_sop();
        int seen = 0;
        for (int c = 0; c < 70; c++) begin
            in_valid = 1'b1;
            in_sop   = 1'b0;
            in_re    = 16'sd777;
            in_im    = 16'sd333;
            @(negedge clk);
            if (out_valid) seen++;
        end
        in_valid = 1'b0;
        chk("R9 ready stays high", ready, 1);
        repeat (300) begin
            @(negedge clk);
            if (out_valid || !ready) seen++;
        end
        chk("R9 no output without sop", seen, 0);
    endtask

    task automatic test_reset_mid();
        int seen = 0;
        for (int n = 0; n < 64; n++) begin
            in_r[n] = rnd(200);
            in_i[n] = rnd(200);
        end
        send_frame(1'b0);
        repeat (30) @(negedge clk);
        do_reset();
        chk("R1 ready after mid reset", ready, 1);
        chk("R1 out_valid after mid reset", out_valid, 0);
        repeat (400) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        chk("R1 abandoned frame silent", seen, 0);
        for (int n = 0; n < 64; n++) begin
            in_r[n] = 40 - n;
            in_i[n] = (n * 5) % 31;
        end
        compute_ref(1'b0);
        send_frame(1'b0);
        collect("R1 frame after reset");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: all requirements, actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        test_reset_state();
        test_impulse();
        test_ramp();
        test_busy_junk();
        test_inverse();
        test_no_sop();
        test_reset_mid();
        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule